// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes everything a processor core must change in the single step of taking an exception. It is given the kind of exception, the PC of the instruction that faulted, whether that instruction sat in a branch delay slot, and the current values of the restart registers, the status bits, the cause register, the debug register and the exception base register. One cycle later it presents the handler PC and the new values of all of that state, ready for the core to commit.

Exceptions take one of three entry paths. General exceptions save a restart address only when the exception level is clear, write a cause code and branch to a handler that is offset from either a boot base or a programmable base. Reset, soft reset and non-maskable interrupt save into a separate error restart register and go to the reset vector. Debug exceptions save into a debug restart register, set one flag per debug event and go to the debug vector. An external interrupt that arrives while the core is in debug mode is handled as a debug interrupt. The delay-slot correction backs the restart address up by one instruction, except for a debug single step.

Top module: `exc_entry_seq`

## Requirements
- R1: A general exception (kinds 3, 4, 5, 6) taken with the exception level clear loads the restart output with PC, or PC−4 when the delay-slot flag is set, sets cause bit 31 to the delay-slot flag, and sets the exception level.
- R2: A general exception taken with the exception level already set leaves the restart output and cause bit 31 at their input values, and the exception level stays set.
- R3: The general handler base is 0xBFC00200 when the boot-vector bit is set, and otherwise the exception base input with bits 9:0 forced to zero.
- R4: The handler offset from the general base is 0x000 for a TLB refill (kind 4) with the exception level clear, 0x200 for an interrupt (kind 3) with the interrupt-vector bit set, and 0x180 for every other general case.
- R5: General exceptions write a 5-bit code into cause bits 6:2: 0 for an interrupt, 11 for coprocessor unusable (kind 5), and the request code input otherwise. Coprocessor unusable also writes the coprocessor number into cause bits 29:28. All other cause bits keep their input values.
- R6: Reset (kind 0), soft reset (kind 1) and NMI (kind 2) load the error restart output with PC, or PC−4 in a delay slot, set the error level and boot-vector bits, and produce PC 0xBFC00000. NMI also sets the NMI bit, soft reset also sets the soft-reset bit, and the general restart output is unchanged.
- R7: Debug exceptions (kinds 7 to 12) load the debug restart output with PC, or PC−4 in a delay slot, set debug mode, produce PC 0xBFC00480, and OR one flag into the debug register: single step bit 0 (kind 7), breakpoint bit 1 (kind 8), data load break bit 2 (kind 9), data store break bit 3 (kind 10), instruction break bit 4 (kind 11), debug interrupt bit 5 (kind 12).
- R8: An interrupt (kind 3) requested while the debug-mode input is set is taken as a debug interrupt: debug bit 5, debug vector, cause code unchanged.
- R9: A debug single step saves the plain PC into the debug restart output even when the delay-slot flag is set.
- R10: After every entry the user-mode and pending delay-slot outputs are 0.
- R11: Error-level and debug entries clear cause bit 31 when the exception level is clear, leave it unchanged when it is set, and leave the cause code field unchanged.
- R12: All results appear, with out_valid high, on the clock edge after the one that samples req_valid; out_valid is low in every cycle that follows a cycle without a request, and reset clears out_valid and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Exception entry request |
| req_kind | input | 4 | Exception kind, 0 to 12 as in the requirements |
| req_code | input | 5 | Cause code for refill and other general exceptions |
| cop_num | input | 2 | Coprocessor number for coprocessor unusable |
| cur_pc | input | XLEN | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction was in a delay slot |
| in_debug | input | 1 | Core is in debug mode |
| st_exl | input | 1 | Exception level bit |
| st_erl | input | 1 | Error level bit |
| st_bev | input | 1 | Boot-vector select bit |
| st_iv | input | 1 | Interrupt-vector select bit |
| st_nmi | input | 1 | NMI status bit |
| st_sr | input | 1 | Soft-reset status bit |
| ebase | input | XLEN | Exception base register |
| epc_in | input | XLEN | Current general restart register |
| errepc_in | input | XLEN | Current error restart register |
| depc_in | input | XLEN | Current debug restart register |
| cause_in | input | 32 | Current cause register |
| debug_in | input | DBG_W | Current debug event flags |
| out_valid | output | 1 | Results below are for a request |
| new_pc | output | XLEN | Handler PC |
| epc_out | output | XLEN | New general restart register |
| errepc_out | output | XLEN | New error restart register |
| depc_out | output | XLEN | New debug restart register |
| exl_out | output | 1 | New exception level bit |
| erl_out | output | 1 | New error level bit |
| bev_out | output | 1 | New boot-vector bit |
| nmi_out | output | 1 | New NMI bit |
| sr_out | output | 1 | New soft-reset bit |
| dbgmode_out | output | 1 | New debug-mode state |
| user_out | output | 1 | New user-mode state |
| dslot_out | output | 1 | New pending delay-slot state |
| cause_out | output | 32 | New cause register |
| debug_out | output | DBG_W | New debug event flags |

## Verification
The bench aims at the delay-slot corner cases: a general exception in a slot with the exception level clear and with it set, where a design that ignored the level would overwrite the restart address, and a single step in a slot, where a design that applied the correction would return one instruction early. It covers every vector selection, including a refill taken with the exception level already set, which must fall back to offset 0x180 instead of 0x000, and an interrupt with the boot vector and interrupt vector both set, which must land at 0xBFC00400. An interrupt in debug mode must set the debug-interrupt flag and leave the cause code alone; a design that skipped the conversion would write code 0 and jump to a general handler. Back-to-back requests and an idle cycle check that results neither slip a cycle nor linger.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [3:0] {
      EK_RESET   = 4'd0,
      EK_SOFTRST = 4'd1,
      EK_NMI     = 4'd2,
      EK_INT     = 4'd3,
      EK_REFILL  = 4'd4,
      EK_COPU    = 4'd5,
      EK_GENERAL = 4'd6,
      EK_DSS     = 4'd7,
      EK_DBP     = 4'd8,
      EK_DDBL    = 4'd9,
      EK_DDBS    = 4'd10,
      EK_DIB     = 4'd11,
      EK_DINT    = 4'd12
   } exc_kind_e;

   typedef enum logic [1:0] {
      PATH_GEN = 2'd0,
      PATH_ERR = 2'd1,
      PATH_DBG = 2'd2
   } exc_path_e;

   localparam int CAUSE_W      = 32;
   localparam int CAUSE_BD_BIT = 31;
   localparam int CAUSE_CE_LO  = 28;
   localparam int CAUSE_CODE_LO = 2;
   localparam int CODE_W       = 5;
   localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
   localparam logic [CODE_W-1:0] CODE_COPU = 5'd11;

   localparam int DBG_MIN_W = 6;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_seq_pkg::*;
#(
   parameter int DBG_W = 6
) (
   input  exc_kind_e        kind_i,
   input  logic             in_debug_i,
   output exc_kind_e        eff_o,
   output exc_path_e        path_o,
   output logic [DBG_W-1:0] dbg_set_o
);

   initial assert (DBG_W >= DBG_MIN_W)
      else $error("exc_classify: DBG_W must be at least %0d", DBG_MIN_W);

   always_comb begin
      eff_o = kind_i;
      if (kind_i == EK_INT && in_debug_i)
         eff_o = EK_DINT;
   end

   always_comb begin
      dbg_set_o = '0;
      unique case (eff_o)
         EK_RESET, EK_SOFTRST, EK_NMI: path_o = PATH_ERR;
         EK_DSS:  begin path_o = PATH_DBG; dbg_set_o[0] = 1'b1; end
         EK_DBP:  begin path_o = PATH_DBG; dbg_set_o[1] = 1'b1; end
         EK_DDBL: begin path_o = PATH_DBG; dbg_set_o[2] = 1'b1; end
         EK_DDBS: begin path_o = PATH_DBG; dbg_set_o[3] = 1'b1; end
         EK_DIB:  begin path_o = PATH_DBG; dbg_set_o[4] = 1'b1; end
         EK_DINT: begin path_o = PATH_DBG; dbg_set_o[5] = 1'b1; end
         default: path_o = PATH_GEN;
      endcase
   end

endmodule

// File: rtl/exc_restart_calc.sv
module exc_restart_calc
   import exc_seq_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  exc_path_e       path_i,
   input  exc_kind_e       eff_i,
   input  logic [XLEN-1:0] cur_pc_i,
   input  logic            in_dslot_i,
   input  logic            st_exl_i,
   input  logic [XLEN-1:0] epc_i,
   input  logic [XLEN-1:0] errepc_i,
   input  logic [XLEN-1:0] depc_i,
   input  logic            bd_i,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] errepc_o,
   output logic [XLEN-1:0] depc_o,
   output logic            bd_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   initial assert (INSN_BYTES > 0)
      else $error("exc_restart_calc: INSN_BYTES must be positive");

   logic [XLEN-1:0] slot_pc;
   assign slot_pc = in_dslot_i ? (cur_pc_i - STEP) : cur_pc_i;

   always_comb begin
      epc_o    = epc_i;
      errepc_o = errepc_i;
      depc_o   = depc_i;
      bd_o     = bd_i;
      unique case (path_i)
         PATH_GEN: begin
            if (!st_exl_i) begin
               epc_o = slot_pc;
               bd_o  = in_dslot_i;
            end
         end
         PATH_ERR: begin
            errepc_o = slot_pc;
            if (!st_exl_i) bd_o = 1'b0;
         end
         PATH_DBG: begin
            depc_o = (eff_i == EK_DSS) ? cur_pc_i : slot_pc;
            if (!st_exl_i) bd_o = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_seq_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter int              ALIGN_BITS    = 10,
   parameter bit              USE_IV        = 1'b1,
   parameter logic [XLEN-1:0] BOOT_GEN_BASE = 32'hBFC0_0200,
   parameter logic [XLEN-1:0] RESET_VEC     = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] DEBUG_VEC     = 32'hBFC0_0480,
   parameter logic [XLEN-1:0] OFF_REFILL    = 32'h0000_0000,
   parameter logic [XLEN-1:0] OFF_INTV      = 32'h0000_0200,
   parameter logic [XLEN-1:0] OFF_COMMON    = 32'h0000_0180
) (
   input  exc_path_e       path_i,
   input  exc_kind_e       eff_i,
   input  logic            st_bev_i,
   input  logic            st_iv_i,
   input  logic            st_exl_i,
   input  logic [XLEN-1:0] ebase_i,
   output logic [XLEN-1:0] pc_o
);

   localparam logic [XLEN-1:0] LOW_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);

   initial assert (ALIGN_BITS > 0 && ALIGN_BITS < XLEN)
      else $error("exc_vector_sel: ALIGN_BITS out of range");

   logic            iv_hit;
   logic [XLEN-1:0] gen_base;
   logic [XLEN-1:0] offset;

   generate
      if (USE_IV) begin : g_iv
         assign iv_hit = st_iv_i;
      end else begin : g_no_iv
         assign iv_hit = 1'b0;
      end
   endgenerate

   assign gen_base = st_bev_i ? BOOT_GEN_BASE : (ebase_i & ~LOW_MASK);

   always_comb begin
      offset = OFF_COMMON;
      if (eff_i == EK_REFILL && !st_exl_i)
         offset = OFF_REFILL;
      else if (eff_i == EK_INT && iv_hit)
         offset = OFF_INTV;
   end

   always_comb begin
      unique case (path_i)
         PATH_ERR: pc_o = RESET_VEC;
         PATH_DBG: pc_o = DEBUG_VEC;
         default:  pc_o = gen_base + offset;
      endcase
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int              XLEN          = 32,
   parameter int              INSN_BYTES    = 4,
   parameter int              ALIGN_BITS    = 10,
   parameter int              DBG_W         = 6,
   parameter bit              OUT_REG       = 1'b1,
   parameter bit              USE_IV        = 1'b1,
   parameter logic [XLEN-1:0] BOOT_GEN_BASE = 32'hBFC0_0200,
   parameter logic [XLEN-1:0] RESET_VEC     = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] DEBUG_VEC     = 32'hBFC0_0480
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [3:0]         req_kind,
   input  logic [CODE_W-1:0]  req_code,
   input  logic [1:0]         cop_num,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic               in_dslot,
   input  logic               in_debug,
   input  logic               st_exl,
   input  logic               st_erl,
   input  logic               st_bev,
   input  logic               st_iv,
   input  logic               st_nmi,
   input  logic               st_sr,
   input  logic [XLEN-1:0]    ebase,
   input  logic [XLEN-1:0]    epc_in,
   input  logic [XLEN-1:0]    errepc_in,
   input  logic [XLEN-1:0]    depc_in,
   input  logic [CAUSE_W-1:0] cause_in,
   input  logic [DBG_W-1:0]   debug_in,
   output logic               out_valid,
   output logic [XLEN-1:0]    new_pc,
   output logic [XLEN-1:0]    epc_out,
   output logic [XLEN-1:0]    errepc_out,
   output logic [XLEN-1:0]    depc_out,
   output logic               exl_out,
   output logic               erl_out,
   output logic               bev_out,
   output logic               nmi_out,
   output logic               sr_out,
   output logic               dbgmode_out,
   output logic               user_out,
   output logic               dslot_out,
   output logic [CAUSE_W-1:0] cause_out,
   output logic [DBG_W-1:0]   debug_out
);

   localparam int FLAG_W = 8;
   localparam int BW     = 4 * XLEN + CAUSE_W + DBG_W + FLAG_W;
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   initial assert (XLEN >= 32)
      else $error("exc_entry_seq: XLEN must be at least 32");

   exc_kind_e        kind;
   exc_kind_e        eff;
   exc_path_e        path;
   logic [DBG_W-1:0] dbg_set;
   logic [XLEN-1:0]  pc_nx, epc_nx, errepc_nx, depc_nx;
   logic             bd_nx;
   logic [CODE_W-1:0] code_nx;
   logic [CAUSE_W-1:0] cause_nx;
   logic [FLAG_W-1:0] flags_nx;
   logic [BW-1:0]    bundle_nx;
   logic [BW-1:0]    bundle;

   assign kind = exc_kind_e'(req_kind);

   exc_classify #(.DBG_W(DBG_W)) u_classify (
      .kind_i     (kind),
      .in_debug_i (in_debug),
      .eff_o      (eff),
      .path_o     (path),
      .dbg_set_o  (dbg_set)
   );

   exc_restart_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_restart (
      .path_i     (path),
      .eff_i      (eff),
      .cur_pc_i   (cur_pc),
      .in_dslot_i (in_dslot),
      .st_exl_i   (st_exl),
      .epc_i      (epc_in),
      .errepc_i   (errepc_in),
      .depc_i     (depc_in),
      .bd_i       (cause_in[CAUSE_BD_BIT]),
      .epc_o      (epc_nx),
      .errepc_o   (errepc_nx),
      .depc_o     (depc_nx),
      .bd_o       (bd_nx)
   );

   exc_vector_sel #(
      .XLEN          (XLEN),
      .ALIGN_BITS    (ALIGN_BITS),
      .USE_IV        (USE_IV),
      .BOOT_GEN_BASE (BOOT_GEN_BASE),
      .RESET_VEC     (RESET_VEC),
      .DEBUG_VEC     (DEBUG_VEC)
   ) u_vector (
      .path_i   (path),
      .eff_i    (eff),
      .st_bev_i (st_bev),
      .st_iv_i  (st_iv),
      .st_exl_i (st_exl),
      .ebase_i  (ebase),
      .pc_o     (pc_nx)
   );

   // Cause code selection for the general path
   always_comb begin
      unique case (eff)
         EK_INT:  code_nx = CODE_INT;
         EK_COPU: code_nx = CODE_COPU;
         default: code_nx = req_code;
      endcase
   end

   always_comb begin
      cause_nx = cause_in;
      cause_nx[CAUSE_BD_BIT] = bd_nx;
      if (path == PATH_GEN) begin
         cause_nx[CAUSE_CODE_LO +: CODE_W] = code_nx;
         if (eff == EK_COPU)
            cause_nx[CAUSE_CE_LO +: 2] = cop_num;
      end
   end

   // Flag order: exl, erl, bev, nmi, sr, debug mode, user, delay slot
   assign flags_nx = {
      st_exl   | (path == PATH_GEN),
      st_erl   | (path == PATH_ERR),
      st_bev   | (path == PATH_ERR),
      st_nmi   | (eff == EK_NMI),
      st_sr    | (eff == EK_SOFTRST),
      in_debug | (path == PATH_DBG),
      1'b0,
      1'b0
   };

   assign bundle_nx = {pc_nx, epc_nx, errepc_nx, depc_nx, cause_nx,
                       debug_in | dbg_set, flags_nx};

   assign {new_pc, epc_out, errepc_out, depc_out, cause_out, debug_out,
           exl_out, erl_out, bev_out, nmi_out, sr_out, dbgmode_out,
           user_out, dslot_out} = bundle;

   generate
      if (OUT_REG) begin : g_reg
         logic [BW-1:0] bundle_q;
         logic          valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bundle_q <= '0;
               valid_q  <= 1'b0;
            end else begin
               valid_q <= req_valid;
               if (req_valid) bundle_q <= bundle_nx;
            end
         end

         assign bundle    = bundle_q;
         assign out_valid = valid_q;

         a_r1_slot_restart: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(path == PATH_GEN && !st_exl && in_dslot))
            |-> (epc_out == $past(cur_pc) - STEP) && cause_out[CAUSE_BD_BIT] && exl_out);

         a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(path == PATH_GEN && st_exl))
            |-> (epc_out == $past(epc_in)) && exl_out
                && (cause_out[CAUSE_BD_BIT] == $past(cause_in[CAUSE_BD_BIT])));

         a_r6_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(path == PATH_ERR))
            |-> erl_out && bev_out && (new_pc == RESET_VEC) && (epc_out == $past(epc_in)));

         a_r7_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(path == PATH_DBG))
            |-> dbgmode_out && (new_pc == DEBUG_VEC)
                && ($countones(debug_out & ~$past(debug_in)) <= 1));

         a_r9_step_plain_pc: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(eff == EK_DSS)) |-> (depc_out == $past(cur_pc)));

         a_r10_mode_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (!user_out && !dslot_out));

         a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid != $past(req_valid)) |-> 1'b0);
      end else begin : g_comb
         assign bundle    = bundle_nx;
         assign out_valid = req_valid;
      end
   endgenerate

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
   import exc_seq_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EPC_IN  = 32'h1111_0040;
   localparam logic [31:0] ERR_IN  = 32'h2222_0080;
   localparam logic [31:0] DEPC_IN = 32'h3333_00C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [3:0]  req_kind = '0;
   logic [4:0]  req_code = '0;
   logic [1:0]  cop_num = '0;
   logic [31:0] cur_pc = '0;
   logic        in_dslot = 1'b0, in_debug = 1'b0;
   logic        st_exl = 1'b0, st_erl = 1'b0, st_bev = 1'b0, st_iv = 1'b0;
   logic        st_nmi = 1'b0, st_sr = 1'b0;
   logic [31:0] ebase = '0;
   logic [31:0] epc_in = EPC_IN, errepc_in = ERR_IN, depc_in = DEPC_IN;
   logic [31:0] cause_in = '0;
   logic [5:0]  debug_in = '0;

   logic        out_valid;
   logic [31:0] new_pc, epc_out, errepc_out, depc_out, cause_out;
   logic        exl_out, erl_out, bev_out, nmi_out, sr_out, dbgmode_out, user_out, dslot_out;
   logic [5:0]  debug_out;

   exc_entry_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_code(req_code), .cop_num(cop_num), .cur_pc(cur_pc), .in_dslot(in_dslot),
      .in_debug(in_debug), .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev),
      .st_iv(st_iv), .st_nmi(st_nmi), .st_sr(st_sr), .ebase(ebase),
      .epc_in(epc_in), .errepc_in(errepc_in), .depc_in(depc_in),
      .cause_in(cause_in), .debug_in(debug_in),
      .out_valid(out_valid), .new_pc(new_pc), .epc_out(epc_out),
      .errepc_out(errepc_out), .depc_out(depc_out), .exl_out(exl_out),
      .erl_out(erl_out), .bev_out(bev_out), .nmi_out(nmi_out), .sr_out(sr_out),
      .dbgmode_out(dbgmode_out), .user_out(user_out), .dslot_out(dslot_out),
      .cause_out(cause_out), .debug_out(debug_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      logic [31:0] pc, epc, errepc, depc, cause;
      logic [5:0]  dbg;
      logic        exl, erl, bev, nmi, sr, dm;
   } exp_t;

   exp_t sbq[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 1'b0;

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // Reference built from the requirements
   function automatic exp_t model(exc_kind_e k, logic [31:0] pc, logic ds,
                                  logic exl, logic bev, logic iv, logic indbg,
                                  logic [31:0] eb, logic [4:0] code, logic [1:0] ce,
                                  logic [31:0] cin, logic [5:0] din);
      exp_t m;
      exc_kind_e e;
      logic [31:0] spc, base, off;
      e = (k == EK_INT && indbg) ? EK_DINT : k;   // R8
      spc = ds ? pc - 32'd4 : pc;
      m.pc = '0; m.epc = EPC_IN; m.errepc = ERR_IN; m.depc = DEPC_IN;
      m.cause = cin; m.dbg = din; m.exl = exl; m.erl = 1'b0; m.bev = bev;
      m.nmi = 1'b0; m.sr = 1'b0; m.dm = indbg;
      case (e)
         EK_RESET, EK_SOFTRST, EK_NMI: begin            // R6 R11
            m.errepc = spc; m.erl = 1'b1; m.bev = 1'b1; m.pc = 32'hBFC0_0000;
            m.nmi = (e == EK_NMI); m.sr = (e == EK_SOFTRST);
            if (!exl) m.cause[31] = 1'b0;
         end
         EK_DSS, EK_DBP, EK_DDBL, EK_DDBS, EK_DIB, EK_DINT: begin  // R7 R9 R11
            m.depc = (e == EK_DSS) ? pc : spc;
            m.dm = 1'b1; m.pc = 32'hBFC0_0480;
            case (e)
               EK_DSS:  m.dbg[0] = 1'b1;
               EK_DBP:  m.dbg[1] = 1'b1;
               EK_DDBL: m.dbg[2] = 1'b1;
               EK_DDBS: m.dbg[3] = 1'b1;
               EK_DIB:  m.dbg[4] = 1'b1;
               default: m.dbg[5] = 1'b1;
            endcase
            if (!exl) m.cause[31] = 1'b0;
         end
         default: begin                                  // R1 R2 R3 R4 R5
            base = bev ? 32'hBFC0_0200 : {eb[31:10], 10'd0};
            if (e == EK_REFILL && !exl) off = 32'h000;
            else if (e == EK_INT && iv) off = 32'h200;
            else off = 32'h180;
            m.pc = base + off;
            if (!exl) begin m.epc = spc; m.cause[31] = ds; end
            m.exl = 1'b1;
            m.cause[6:2] = (e == EK_INT) ? 5'd0 : (e == EK_COPU) ? 5'd11 : code;
            if (e == EK_COPU) m.cause[29:28] = ce;
         end
      endcase
      return m;
   endfunction

   // Driver: presents one request per call and queues its expectation
   task automatic fire(input exc_kind_e k, input logic [31:0] pc, input logic ds,
                       input logic exl, input logic bev, input logic iv, input logic indbg,
                       input logic [31:0] eb, input logic [4:0] code, input logic [1:0] ce,
                       input logic [31:0] cin, input logic [5:0] din);
      @(negedge clk);
      req_kind = k; cur_pc = pc; in_dslot = ds; st_exl = exl; st_bev = bev;
      st_iv = iv; in_debug = indbg; ebase = eb; req_code = code; cop_num = ce;
      cause_in = cin; debug_in = din; req_valid = 1'b1;
      sbq.push_back(model(k, pc, ds, exl, bev, iv, indbg, eb, code, ce, cin, din));
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: compares each result with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sbq.size() == 0) begin
            chk("R12", "unexpected out_valid", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            chk("R3 R4 R6 R7", "new_pc", new_pc, e.pc);
            chk("R1 R2", "epc_out", epc_out, e.epc);
            chk("R6", "errepc_out", errepc_out, e.errepc);
            chk("R7 R9", "depc_out", depc_out, e.depc);
            chk("R5 R11", "cause_out", cause_out, e.cause);
            chk("R7 R8", "debug_out", {26'd0, debug_out}, {26'd0, e.dbg});
            chk("R1 R2", "exl_out", {31'd0, exl_out}, {31'd0, e.exl});
            chk("R6", "erl/bev/nmi/sr", {28'd0, erl_out, bev_out, nmi_out, sr_out},
                {28'd0, e.erl, e.bev, e.nmi, e.sr});
            chk("R7", "dbgmode_out", {31'd0, dbgmode_out}, {31'd0, e.dm});
            chk("R10", "user/dslot", {30'd0, user_out, dslot_out}, 32'd0);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12", "reset out_valid", {31'd0, out_valid}, 32'd0);
      chk("R12", "reset new_pc", new_pc, 32'd0);
      chk("R12", "reset epc_out", epc_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R4: general, not in slot, programmable base with low bits set
      fire(EK_GENERAL, 32'h8000_4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_13FF, 5'd4, 2'd0, 32'h0000_FF00, 6'd0);
      idle();
      // R1: general in a delay slot
      fire(EK_GENERAL, 32'h8000_4010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_1000, 5'd10, 2'd0, 32'h0000_0000, 6'd0);
      idle();
      // R2: level already set, in slot, BD input clear
      fire(EK_GENERAL, 32'h8000_4020, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_1000, 5'd5, 2'd0, 32'h0000_0300, 6'd0);
      // R2: level set, BD input set, not in slot (back to back)
      fire(EK_GENERAL, 32'h8000_4030, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_1000, 5'd12, 2'd0, 32'h8000_0000, 6'd0);
      idle();
      // R4 R3: refill with level clear, boot base
      fire(EK_REFILL, 32'h0040_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h8000_1000, 5'd2, 2'd0, 32'h0, 6'd0);
      // R4: refill with level set falls back to 0x180
      fire(EK_REFILL, 32'h0040_0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h9000_0000, 5'd3, 2'd0, 32'h0, 6'd0);
      // R4 R5: interrupt with vector bit, then without, then with boot base
      fire(EK_INT, 32'h0040_0100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h8000_2000, 5'd9, 2'd0, 32'h0000_007C, 6'd0);
      fire(EK_INT, 32'h0040_0104, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_2000, 5'd9, 2'd0, 32'h0, 6'd0);
      fire(EK_INT, 32'h0040_0108, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8000_2000, 5'd9, 2'd0, 32'h0, 6'd0);
      idle();
      // R5: coprocessor unusable replaces the CE field
      fire(EK_COPU, 32'h0040_0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_3000, 5'd1, 2'd2, 32'h1000_0000, 6'd0);
      idle();
      // R6 R11: reset in slot, soft reset, NMI with level set and BD held
      fire(EK_RESET, 32'h0040_0300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h8000_0010, 6'd0);
      fire(EK_SOFTRST, 32'h0040_0304, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h0, 6'd0);
      fire(EK_NMI, 32'h0040_0308, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h8000_0024, 6'd0);
      idle();
      // R7: each debug kind, earlier flags preserved
      fire(EK_DBP, 32'h0040_0400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h8000_0000, 6'd0);
      fire(EK_DDBL, 32'h0040_0404, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h0, 6'b000010);
      fire(EK_DDBS, 32'h0040_0408, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0, 5'd0, 2'd0, 32'h8000_0000, 6'b000100);
      fire(EK_DIB, 32'h0040_040C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h0, 6'd0);
      fire(EK_DINT, 32'h0040_0410, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 5'd0, 2'd0, 32'h0, 6'd0);
      // R9: single step in a slot keeps the plain PC
      fire(EK_DSS, 32'h0040_0500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 5'd0, 2'd0, 32'h0, 6'd0);
      // R8: interrupt while in debug mode becomes a debug interrupt
      fire(EK_INT, 32'h0040_0600, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h8000_2000, 5'd7, 2'd0, 32'h0000_0044, 6'd0);
      idle();
      @(negedge clk);
      // R12: no result after an idle cycle, scoreboard drained
      chk("R12", "idle out_valid", {31'd0, out_valid}, 32'd0);
      chk("R12", "pending results", sbq.size(), 32'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule